// File: doc/BRIEF.md
# PWM Trip-Zone Fault Handler

This block sits between the PWM waveform generator and the output pads. When a fault input is asserted, it overrides each PWM output with a programmed safe level. The safe level can be high, low, high-impedance or no change. There are eight trip sources by default: three external fault pins, an active-low encoder error line, a clock-failure indication, a debug-halt request and a parameterised number of digital-compare events.

Each source can be enabled for two trip classes, or for neither:

- **One-shot class.** It latches and holds the outputs in the safe state until software clears it.
- **Cycle-by-cycle class.** It limits current. It holds the override only until the next counter-equals-zero instant at which no enabled cycle-by-cycle source is still active.

The override path from the trip inputs to the outputs is purely combinational. An enabled fault therefore reaches the pads within the same cycle, without waiting for a clock edge or for an interrupt handler.

All control and status pins are plain level or strobe signals. There is no streaming interface, so no valid/ready handshake or back-pressure applies.

Top module: `tz_fault_guard`

## Requirements
- R1: Each output has a 2-bit safe mode: 00 keeps the PWM input, 01 forces high, 10 forces low, 11 drops the output enable and drives level 0. Output g uses mode bits [2g+1:2g]. While no trip is in force, every output follows its PWM input with the enable high.
- R2: An enabled trip source changes the outputs in the same cycle it asserts, through a path with no register.
- R3: When a one-shot source fires, the one-shot flag sets and the override holds after the source goes away, until a one-shot clear strobe is given.
- R4: A one-shot clear strobe given while an enabled one-shot source is still active leaves the flag set.
- R5: The cycle-by-cycle override is released at a clock edge where the counter-zero strobe is high and no enabled cycle-by-cycle source is active. The outputs follow the PWM inputs from the next cycle.
- R6: At a counter-zero edge where an enabled cycle-by-cycle source is still active, the override is kept.
- R7: A source enabled in neither class has no effect on outputs, flags or the interrupt.
- R8: Source bit positions in both enable vectors are fixed:
  - bits 0-2 are the fault pins;
  - bit 3 is the inverted encoder error line (a trip while the line is low);
  - bit 4 is clock failure;
  - bit 5 is debug halt;
  - bits 6 and up are the digital-compare events.
- R9: The cycle-by-cycle status flag sets on any enabled cycle-by-cycle trip and holds until its clear strobe, independent of the override release. A clear while the trip is active leaves the flag set.
- R10: The interrupt flag sets on a trip of a class whose interrupt-enable bit is high (bit 0 one-shot, bit 1 cycle-by-cycle). It holds until the interrupt clear strobe, and a new trip in the same cycle as the clear wins.
- R11: After reset all flags and the interrupt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| pwm_i | input | NUM_OUT | PWM levels from the waveform generator |
| trip_pin_i | input | 3 | External fault pins, active high |
| enc_err_ni | input | 1 | Encoder error line, active low |
| clk_fail_i | input | 1 | Clock-failure indication |
| dbg_halt_i | input | 1 | Debug-halt request |
| dc_evt_i | input | NUM_DC | Digital-compare trip events |
| ost_en_i | input | 6+NUM_DC | Per-source one-shot enable |
| cbc_en_i | input | 6+NUM_DC | Per-source cycle-by-cycle enable |
| safe_mode_i | input | 2*NUM_OUT | Safe mode per output |
| cnt_zero_i | input | 1 | Counter-equals-zero strobe |
| ost_clr_i | input | 1 | One-shot flag clear strobe |
| cbc_clr_i | input | 1 | Cycle-by-cycle flag clear strobe |
| irq_en_i | input | 2 | Interrupt enable per class |
| irq_clr_i | input | 1 | Interrupt flag clear strobe |
| pwm_o | output | NUM_OUT | Output levels after override |
| pwm_oe_o | output | NUM_OUT | Output enables (0 = high-impedance) |
| ost_flag_o | output | 1 | Latched one-shot trip flag |
| cbc_flag_o | output | 1 | Latched cycle-by-cycle trip flag |
| irq_o | output | 1 | Interrupt request flag |

## Verification
The bench targets the following corner cases:

- **Clear racing a fault.** A one-shot clear given while the fault is still present must not drop the latch. A design that lets the clear win would release the outputs into a live fault.
- **Counter-zero with the fault still active.** A cycle-by-cycle trip that is still active at counter-zero must keep the override. A design that releases on every zero strobe would let one unprotected cycle through each period.
- **Same-cycle response.** The outputs are checked before the next clock edge after a source asserts. A registered override shows up as a one-cycle late force.
- **Bit order, disabled sources and the encoder inversion.** Random enable masks, disabled-source sweeps and the high-impedance mode catch a swapped source bit, a missing inversion on the encoder line, or an enable left driven in high-impedance mode.

// File: rtl/tz_pkg.sv
`timescale 1ns/1ps
package tz_pkg;
  // Fixed sources ahead of the digital-compare events
  localparam int N_FIXED_SRC = 6;

  typedef enum logic [1:0] {
    SAFE_KEEP = 2'b00,
    SAFE_HIGH = 2'b01,
    SAFE_LOW  = 2'b10,
    SAFE_HIZ  = 2'b11
  } safe_e;
endpackage

// File: rtl/tz_src_qual.sv
`timescale 1ns/1ps
// Qualifies raw trip sources with the per-class enables (R7).
module tz_src_qual #(
  parameter int NSRC = 8
) (
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] ost_en_i,
  input  logic [NSRC-1:0] cbc_en_i,
  output logic            ost_hit_o,
  output logic            cbc_hit_o
);
  logic [NSRC-1:0] ost_m, cbc_m;

  always_comb begin
    ost_m     = src_i & ost_en_i;
    cbc_m     = src_i & cbc_en_i;
    ost_hit_o = |ost_m;
    cbc_hit_o = |cbc_m;
  end
endmodule

// File: rtl/tz_trip_state.sv
`timescale 1ns/1ps
// Latched state of both trip classes and the interrupt flag.
module tz_trip_state (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ost_hit_i,
  input  logic       cbc_hit_i,
  input  logic       cnt_zero_i,
  input  logic       ost_clr_i,
  input  logic       cbc_clr_i,
  input  logic [1:0] irq_en_i,
  input  logic       irq_clr_i,
  output logic       ost_q_o,
  output logic       cbc_hold_o,
  output logic       cbc_flag_o,
  output logic       irq_o
);
  logic ost_q, cbc_hold, cbc_flag, irq_q;
  logic irq_set;

  always_comb begin
    irq_set = (ost_hit_i & irq_en_i[0]) | (cbc_hit_i & irq_en_i[1]);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ost_q    <= 1'b0;
      cbc_hold <= 1'b0;
      cbc_flag <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      // R3/R4: a live source outranks the clear
      ost_q    <= ost_hit_i | (ost_q & ~ost_clr_i);
      // R5/R6: re-evaluate at counter zero, accumulate otherwise
      if (cnt_zero_i) cbc_hold <= cbc_hit_i;
      else            cbc_hold <= cbc_hold | cbc_hit_i;
      // R9
      cbc_flag <= cbc_hit_i | (cbc_flag & ~cbc_clr_i);
      // R10
      irq_q    <= irq_set | (irq_q & ~irq_clr_i);
    end
  end

  assign ost_q_o    = ost_q;
  assign cbc_hold_o = cbc_hold;
  assign cbc_flag_o = cbc_flag;
  assign irq_o      = irq_q;
endmodule

// File: rtl/tz_out_force.sv
`timescale 1ns/1ps
// Combinational override of each output (R1, R2).
module tz_out_force
  import tz_pkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input  logic                 trip_i,
  input  logic [2*NUM_OUT-1:0] mode_i,
  input  logic [NUM_OUT-1:0]   pwm_i,
  output logic [NUM_OUT-1:0]   pwm_o,
  output logic [NUM_OUT-1:0]   oe_o
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    safe_e md;
    assign md = safe_e'(mode_i[2*g +: 2]);

    always_comb begin
      pwm_o[g] = pwm_i[g];
      oe_o[g]  = 1'b1;
      if (trip_i) begin
        unique case (md)
          SAFE_HIGH: pwm_o[g] = 1'b1;
          SAFE_LOW:  pwm_o[g] = 1'b0;
          SAFE_HIZ: begin
            pwm_o[g] = 1'b0;
            oe_o[g]  = 1'b0;
          end
          default:   pwm_o[g] = pwm_i[g];
        endcase
      end
    end
  end
endmodule

// File: rtl/tz_fault_guard.sv
`timescale 1ns/1ps
module tz_fault_guard
  import tz_pkg::*;
#(
  parameter int NUM_OUT = 2,
  parameter int NUM_DC  = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_OUT-1:0]              pwm_i,
  input  logic [2:0]                      trip_pin_i,
  input  logic                            enc_err_ni,
  input  logic                            clk_fail_i,
  input  logic                            dbg_halt_i,
  input  logic [NUM_DC-1:0]               dc_evt_i,
  input  logic [N_FIXED_SRC+NUM_DC-1:0]   ost_en_i,
  input  logic [N_FIXED_SRC+NUM_DC-1:0]   cbc_en_i,
  input  logic [2*NUM_OUT-1:0]            safe_mode_i,
  input  logic                            cnt_zero_i,
  input  logic                            ost_clr_i,
  input  logic                            cbc_clr_i,
  input  logic [1:0]                      irq_en_i,
  input  logic                            irq_clr_i,
  output logic [NUM_OUT-1:0]              pwm_o,
  output logic [NUM_OUT-1:0]              pwm_oe_o,
  output logic                            ost_flag_o,
  output logic                            cbc_flag_o,
  output logic                            irq_o
);
  localparam int NSRC = N_FIXED_SRC + NUM_DC;

  logic [NSRC-1:0] src_w;
  logic ost_hit_w, cbc_hit_w, ost_q_w, cbc_hold_w, trip_any_w;

  // R8: fixed source ordering, encoder line inverted
  assign src_w = {dc_evt_i, dbg_halt_i, clk_fail_i, ~enc_err_ni, trip_pin_i};

  tz_src_qual #(.NSRC(NSRC)) u_qual (
    .src_i     (src_w),
    .ost_en_i  (ost_en_i),
    .cbc_en_i  (cbc_en_i),
    .ost_hit_o (ost_hit_w),
    .cbc_hit_o (cbc_hit_w)
  );

  tz_trip_state u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ost_hit_i  (ost_hit_w),
    .cbc_hit_i  (cbc_hit_w),
    .cnt_zero_i (cnt_zero_i),
    .ost_clr_i  (ost_clr_i),
    .cbc_clr_i  (cbc_clr_i),
    .irq_en_i   (irq_en_i),
    .irq_clr_i  (irq_clr_i),
    .ost_q_o    (ost_q_w),
    .cbc_hold_o (cbc_hold_w),
    .cbc_flag_o (cbc_flag_o),
    .irq_o      (irq_o)
  );

  // R2: live hits bypass the registers
  assign trip_any_w = ost_hit_w | cbc_hit_w | ost_q_w | cbc_hold_w;
  assign ost_flag_o = ost_q_w;

  tz_out_force #(.NUM_OUT(NUM_OUT)) u_force (
    .trip_i (trip_any_w),
    .mode_i (safe_mode_i),
    .pwm_i  (pwm_i),
    .pwm_o  (pwm_o),
    .oe_o   (pwm_oe_o)
  );
endmodule

// File: rtl/tz_fault_guard_chk.sv
`timescale 1ns/1ps
module tz_fault_guard_chk #(
  parameter int NSRC = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSRC-1:0] src_w,
  input logic [NSRC-1:0] ost_en_i,
  input logic [NSRC-1:0] cbc_en_i,
  input logic            cnt_zero_i,
  input logic            ost_clr_i,
  input logic            irq_clr_i,
  input logic            ost_flag_o,
  input logic            irq_o,
  input logic            cbc_hold_w,
  input logic            trip_any_w,
  input logic [1:0]      mode0,
  input logic            pwm0,
  input logic            oe0
);
  logic ost_live, cbc_live;
  assign ost_live = |(src_w & ost_en_i);
  assign cbc_live = |(src_w & cbc_en_i);

  a_r3_ost_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ost_flag_o && !ost_clr_i) |=> ost_flag_o);

  a_r4_clear_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ost_live && ost_clr_i) |=> ost_flag_o);

  a_r6_cbc_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_zero_i && cbc_live) |=> cbc_hold_w);

  a_r5_cbc_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_zero_i && !cbc_live) |=> !cbc_hold_w);

  a_r10_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);

  a_r2_live_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ost_live && mode0 == 2'b01) |-> pwm0);

  a_r1_hiz_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_any_w && mode0 == 2'b11) |-> (!oe0 && !pwm0));
endmodule

bind tz_fault_guard tz_fault_guard_chk #(.NSRC(NSRC)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_w      (src_w),
  .ost_en_i   (ost_en_i),
  .cbc_en_i   (cbc_en_i),
  .cnt_zero_i (cnt_zero_i),
  .ost_clr_i  (ost_clr_i),
  .irq_clr_i  (irq_clr_i),
  .ost_flag_o (ost_flag_o),
  .irq_o      (irq_o),
  .cbc_hold_w (cbc_hold_w),
  .trip_any_w (trip_any_w),
  .mode0      (safe_mode_i[1:0]),
  .pwm0       (pwm_o[0]),
  .oe0        (pwm_oe_o[0])
);

// File: tb/tz_fault_guard_tb_top.sv
`timescale 1ns/1ps
module tz_fault_guard_tb_top;
  localparam int NUM_OUT = 2;
  localparam int NUM_DC  = 2;
  localparam int NSRC    = 6 + NUM_DC;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NUM_OUT-1:0] pwm_i = '0;
  logic [2:0] trip_pin_i = '0;
  logic enc_err_ni = 1'b1;
  logic clk_fail_i = 1'b0, dbg_halt_i = 1'b0;
  logic [NUM_DC-1:0] dc_evt_i = '0;
  logic [NSRC-1:0] ost_en_i = '0, cbc_en_i = '0;
  logic [2*NUM_OUT-1:0] safe_mode_i = '0;
  logic cnt_zero_i = 1'b0, ost_clr_i = 1'b0, cbc_clr_i = 1'b0, irq_clr_i = 1'b0;
  logic [1:0] irq_en_i = '0;
  logic [NUM_OUT-1:0] pwm_o, pwm_oe_o;
  logic ost_flag_o, cbc_flag_o, irq_o;

  int checks = 0;
  int errors = 0;
  logic m_ost = 0, m_hold = 0, m_cflag = 0, m_irq = 0;

  always #5 clk_i = ~clk_i;

  tz_fault_guard #(.NUM_OUT(NUM_OUT), .NUM_DC(NUM_DC)) dut_i (.*);

  function automatic logic [NSRC-1:0] src_vec();
    return {dc_evt_i, dbg_halt_i, clk_fail_i, ~enc_err_ni, trip_pin_i};
  endfunction
  function automatic logic ohit();
    return |(src_vec() & ost_en_i);
  endfunction
  function automatic logic chit();
    return |(src_vec() & cbc_en_i);
  endfunction

  task automatic chk(string what, string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Check combinational outputs mid-cycle, then advance model at the edge
  task automatic step(string tag);
    logic trip;
    logic [NUM_OUT-1:0] ep, eo;
    #3;
    trip = ohit() | chit() | m_ost | m_hold;
    for (int g = 0; g < NUM_OUT; g++) begin
      ep[g] = pwm_i[g];
      eo[g] = 1'b1;
      if (trip) begin
        case (safe_mode_i[2*g +: 2])
          2'b01: ep[g] = 1'b1;
          2'b10: ep[g] = 1'b0;
          2'b11: begin ep[g] = 1'b0; eo[g] = 1'b0; end
          default: ep[g] = pwm_i[g];
        endcase
      end
    end
    chk("pwm_o R1 R2 R5 R6", tag, 4'(pwm_o), 4'(ep));
    chk("pwm_oe_o R1", tag, 4'(pwm_oe_o), 4'(eo));
    chk("ost_flag_o R3 R4", tag, 4'(ost_flag_o), 4'(m_ost));
    chk("cbc_flag_o R9", tag, 4'(cbc_flag_o), 4'(m_cflag));
    chk("irq_o R10", tag, 4'(irq_o), 4'(m_irq));
    @(posedge clk_i);
    if (rst_ni) begin
      m_irq   = (ohit() & irq_en_i[0]) | (chit() & irq_en_i[1]) | (m_irq & ~irq_clr_i);
      m_cflag = chit() | (m_cflag & ~cbc_clr_i);
      m_hold  = cnt_zero_i ? chit() : (m_hold | chit());
      m_ost   = ohit() | (m_ost & ~ost_clr_i);
    end
    #1;
  endtask

  task automatic quiet();
    trip_pin_i = '0; enc_err_ni = 1'b1; clk_fail_i = 0; dbg_halt_i = 0; dc_evt_i = '0;
    cnt_zero_i = 0; ost_clr_i = 0; cbc_clr_i = 0; irq_clr_i = 0;
  endtask

  task automatic clear_all();
    quiet(); cnt_zero_i = 1; ost_clr_i = 1; cbc_clr_i = 1; irq_clr_i = 1;
    step("clear"); quiet();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R11: reset state, outputs pass through
    pwm_i = 2'b10; safe_mode_i = 4'b0101;
    step("R11 reset");

    // R7: all sources high with nothing enabled
    trip_pin_i = 3'b111; enc_err_ni = 0; clk_fail_i = 1; dbg_halt_i = 1; dc_evt_i = '1;
    irq_en_i = 2'b11; step("R7 disabled"); step("R7 disabled");
    quiet();

    // R8: debug halt on bit 5 as one-shot, high-Z on output 1
    ost_en_i = 8'h20; safe_mode_i = 4'b1110; dbg_halt_i = 1;
    step("R8 R2 halt"); dbg_halt_i = 0; step("R3 latched"); step("R3 latched");
    // R4: clear while active
    dbg_halt_i = 1; ost_clr_i = 1; step("R4 clr blocked");
    dbg_halt_i = 0; ost_clr_i = 1; step("R3 clr"); quiet(); step("R3 released");
    // R8: inverted encoder line on bit 3, cycle-by-cycle
    clear_all(); ost_en_i = '0; cbc_en_i = 8'h08; safe_mode_i = 4'b0110; irq_en_i = 2'b10;
    enc_err_ni = 0; step("R8 enc");
    cnt_zero_i = 1; step("R6 kept");
    enc_err_ni = 1; cnt_zero_i = 0; step("R6 hold"); step("R6 hold");
    cnt_zero_i = 1; step("R5 release"); cnt_zero_i = 0; step("R5 free");
    // R10: trip and clear in same cycle
    dc_evt_i = 2'b10; cbc_en_i = 8'h80; irq_clr_i = 1; step("R10 set wins");
    quiet(); step("R10 hold"); irq_clr_i = 1; step("R10 clr"); quiet();
    cbc_clr_i = 1; step("R9 clr"); quiet(); step("R9 done");

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      if (i % 64 == 0) begin
        ost_en_i = NSRC'($urandom()) & NSRC'($urandom());
        cbc_en_i = NSRC'($urandom());
        safe_mode_i = 4'($urandom());
        irq_en_i = 2'($urandom());
      end
      pwm_i = 2'($urandom());
      trip_pin_i[0] = ($urandom_range(0, 19) == 0);
      trip_pin_i[1] = ($urandom_range(0, 19) == 0);
      trip_pin_i[2] = ($urandom_range(0, 19) == 0);
      enc_err_ni    = ($urandom_range(0, 19) != 0);
      clk_fail_i    = ($urandom_range(0, 29) == 0);
      dbg_halt_i    = ($urandom_range(0, 29) == 0);
      dc_evt_i[0]   = ($urandom_range(0, 19) == 0);
      dc_evt_i[1]   = ($urandom_range(0, 19) == 0);
      cnt_zero_i    = ($urandom_range(0, 5) == 0);
      ost_clr_i     = ($urandom_range(0, 7) == 0);
      cbc_clr_i     = ($urandom_range(0, 7) == 0);
      irq_clr_i     = ($urandom_range(0, 7) == 0);
      step("random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule